// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors held in a word-addressed memory and streams the referenced frame bytes out, one byte per valid cycle. Each descriptor is two 32-bit words. The word at even offset `base + 2*i` holds the word address of the buffer. The word at `base + 2*i + 1` is the control word. Software hands a descriptor to the engine by clearing its used flag. The engine hands it back by writing the control word again with the used flag set, together with any completion status.

Software loads the ring base, fills the descriptors and pulses `start`. The engine then consumes descriptors in ring order until it reaches one that is still marked used. A frame may span several buffers. If the ring runs dry in the middle of a frame, the engine tags the descriptor it met, flags the cut-short frame on the stream, and stops. A `halt` request stops the engine at the next frame boundary. Collision handling and CRC computation are left to the stage that follows; the engine only marks, on the final byte, whether a CRC is to be appended.

Top module: `tx_desc_ring_engine`

## Requirements
- R1: After reset `busy`, `tx_valid` and `mem_req` are all low, and the ring index is 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. The engine first reads the control word at `base + 2*i + 1` and then the buffer address word at `base + 2*i`.
- R3: A descriptor whose control bits 10:0 give a length L ≥ 1 produces exactly L bytes on `tx_data`. Each byte comes with `tx_valid`. The bytes are taken from consecutive words starting at the buffer word address, least significant byte of each word first.
- R4: `tx_last` is high only on the final byte of a buffer whose control bit 15 (end of frame) is set. The bytes of all buffers in a frame follow in ring order.
- R5: On the byte that carries `tx_last`, `tx_crc` is high when control bit 16 is clear and low when it is set.
- R6: Each consumed descriptor has its control word rewritten with bit 31 (used) set and the other control bits kept. For a buffer with bit 15 set, the same write places `underrun_in` in bit 28 and `retry_in` in bit 29. For other buffers both bits are written as 0.
- R7: After a descriptor with control bit 30 set, the next fetch is entry 0 at the ring base. After any other descriptor, the next fetch is the following entry.
- R8: A descriptor found with bit 31 set at the start of a frame stops the engine. `busy` falls three cycles after the start pulse edge, the descriptor is not written, and no memory request occurs until the next `start`.
- R9: A descriptor found with bit 31 set in the middle of a frame is rewritten with bit 27 also set. `tx_abort` pulses for one cycle, no `tx_last` is given, and `busy` falls.
- R10: A `halt` pulse lets the frame in progress finish and write back, then `busy` falls without fetching the next descriptor. The next `start` resumes at the following descriptor.
- R11: Writing the ring base register (`base_we`) also resets the ring index to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Load ring base word address and reset index |
| base_wdata | input | AW | Ring base word address |
| start | input | 1 | Begin processing at current index (idle only) |
| halt | input | 1 | Stop at the next frame boundary |
| busy | output | 1 | Engine is processing descriptors |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| underrun_in | input | 1 | Underrun status, sampled at final-buffer write-back |
| retry_in | input | 1 | Retry-limit status, sampled at final-buffer write-back |
| tx_valid | output | 1 | Byte valid on tx_data |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_crc | output | 1 | Append CRC after this frame (with tx_last) |
| tx_abort | output | 1 | Frame cut short by ring exhaustion |

## Verification
`busy` is due one cycle after the edge that samples `start`. When the first descriptor is already used, `busy` is due low three cycles after that edge. The bench samples `busy` at exactly those falling edges. Bytes and their `tx_last`/`tx_crc` flags appear some cycles after the fetches, at a rate set by the word reads. They are therefore captured at each falling edge where `tx_valid` is high, and compared by position in the stream rather than by cycle. Descriptor write-backs and the absence of memory traffic are checked once `busy` has dropped, by reading the bench memory and comparing a request counter over a 20-cycle quiet window.

// File: rtl/tdr_pkg.sv
// Shared constants and types for the transmit descriptor ring engine.
// Assumes a 32-bit control word with fixed field positions.
package tdr_pkg;
    localparam int LEN_W   = 11;
    localparam int B_LAST  = 15;
    localparam int B_NOCRC = 16;
    localparam int B_EXH   = 27;
    localparam int B_UNDR  = 28;
    localparam int B_RETRY = 29;
    localparam int B_WRAP  = 30;
    localparam int B_USED  = 31;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RDC, ST_RDA, ST_LDADR, ST_RDW, ST_LAT, ST_EMIT, ST_WB, ST_XWB
    } tdr_state_e;
endpackage

// File: rtl/tdr_ring_ptr.sv
// Ring position register: holds the ring base and the entry index and
// forms the two descriptor word addresses. Assumes AW >= 2; address
// arithmetic wraps modulo 2**AW.
module tdr_ring_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [AW-1:0] base_in,
    input  logic          adv,
    input  logic          wrap,
    output logic [AW-1:0] adr_word_o,
    output logic [AW-1:0] ctl_word_o
);
    localparam int IW = AW - 1;

    logic [AW-1:0] base_q;
    logic [IW-1:0] idx_q;

    // Base load restarts at entry 0; advance steps or returns to base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (base_we) begin
            base_q <= base_in;
            idx_q  <= '0;
        end else if (adv) begin
            idx_q <= wrap ? '0 : idx_q + IW'(1);
        end
    end

    assign adr_word_o = base_q + {idx_q, 1'b0};
    assign ctl_word_o = adr_word_o + AW'(1);

    // R7
    wrap_rtn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wrap && !base_we) |=> (adr_word_o == base_q));
    // R11
    base_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> (adr_word_o == $past(base_in)));
endmodule

// File: rtl/tdr_byte_ser.sv
// Word-to-byte serializer: holds one fetched 32-bit word and the bytes
// left in the current buffer, and steps out bytes lane 0 first.
// Assumes step is only given while bytes remain.
module tdr_byte_ser #(
    parameter int LEN_W = tdr_pkg::LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_len,
    input  logic [LEN_W-1:0] len_in,
    input  logic             load_word,
    input  logic [31:0]      word_in,
    input  logic             step,
    output logic [7:0]       byte_o,
    output logic             word_end,
    output logic             buf_end
);
    logic [31:0]      word_q;
    logic [1:0]       lane_q;
    logic [LEN_W-1:0] remain_q;

    // Remaining-byte counter, loaded per buffer and counted down per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        remain_q <= '0;
        else if (load_len) remain_q <= len_in;
        else if (step)     remain_q <= remain_q - LEN_W'(1);
    end

    // Word holder and lane pointer, restarted on every new word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            lane_q <= '0;
        end else if (load_word) begin
            word_q <= word_in;
            lane_q <= '0;
        end else if (step) begin
            lane_q <= lane_q + 2'd1;
        end
    end

    assign byte_o   = word_q[{lane_q, 3'b000} +: 8];
    assign word_end = (lane_q == 2'd3);
    assign buf_end  = (remain_q == LEN_W'(1));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remain_q != '0));
endmodule

// File: rtl/tx_desc_ring_engine.sv
// Transmit descriptor ring engine: fetches descriptors, streams buffer
// bytes, writes completion back into each control word. Assumes memory
// returns read data one cycle after a read request and never stalls,
// and that the byte sink always accepts.
module tx_desc_ring_engine
    import tdr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          start,
    input  logic          halt,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          underrun_in,
    input  logic          retry_in,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          tx_crc,
    output logic          tx_abort
);
    tdr_state_e    state_q, state_d;
    logic [31:0]   ctrl_q;
    logic [AW-1:0] bufp_q;
    logic          in_frame_q, halt_q;
    logic [AW-1:0] adr_word, ctl_word;
    logic          adv, ctrl_ld, bufp_ld, bufp_inc, frame_set, frame_clr;
    logic          ld_len, ld_word, step, word_end, buf_end;

    tdr_ring_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_in(base_wdata),
        .adv(adv), .wrap(ctrl_q[B_WRAP]),
        .adr_word_o(adr_word), .ctl_word_o(ctl_word)
    );

    tdr_byte_ser #(.LEN_W(LEN_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .load_len(ld_len), .len_in(ctrl_q[LEN_W-1:0]),
        .load_word(ld_word), .word_in(mem_rdata), .step(step),
        .byte_o(tx_data), .word_end(word_end), .buf_end(buf_end)
    );

    // Sequencer: next state, memory access and stream strobes.
    always_comb begin
        state_d   = state_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ctl_word;
        mem_wdata = ctrl_q;
        adv = 1'b0; ctrl_ld = 1'b0; bufp_ld = 1'b0; bufp_inc = 1'b0;
        frame_set = 1'b0; frame_clr = 1'b0;
        ld_len = 1'b0; ld_word = 1'b0; step = 1'b0;
        tx_valid = 1'b0; tx_abort = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RDC;
            ST_RDC: begin
                mem_req = 1'b1;
                state_d = ST_RDA;
            end
            ST_RDA: begin
                if (!in_frame_q && halt_q) begin
                    state_d = ST_IDLE;
                end else if (mem_rdata[B_USED]) begin
                    ctrl_ld = in_frame_q;
                    state_d = in_frame_q ? ST_XWB : ST_IDLE;
                end else begin
                    ctrl_ld  = 1'b1;
                    mem_req  = 1'b1;
                    mem_addr = adr_word;
                    state_d  = ST_LDADR;
                end
            end
            ST_LDADR: begin
                bufp_ld = 1'b1;
                ld_len  = 1'b1;
                state_d = (ctrl_q[LEN_W-1:0] == '0) ? ST_WB : ST_RDW;
            end
            ST_RDW: begin
                mem_req  = 1'b1;
                mem_addr = bufp_q;
                state_d  = ST_LAT;
            end
            ST_LAT: begin
                ld_word  = 1'b1;
                bufp_inc = 1'b1;
                state_d  = ST_EMIT;
            end
            ST_EMIT: begin
                tx_valid = 1'b1;
                step     = 1'b1;
                if (buf_end)       state_d = ST_WB;
                else if (word_end) state_d = ST_RDW;
            end
            ST_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                mem_wdata[B_USED]  = 1'b1;
                mem_wdata[B_UNDR]  = ctrl_q[B_LAST] & underrun_in;
                mem_wdata[B_RETRY] = ctrl_q[B_LAST] & retry_in;
                adv = 1'b1;
                if (ctrl_q[B_LAST]) begin
                    frame_clr = 1'b1;
                    state_d   = halt_q ? ST_IDLE : ST_RDC;
                end else begin
                    frame_set = 1'b1;
                    state_d   = ST_RDC;
                end
            end
            ST_XWB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_wdata[B_EXH] = 1'b1;
                tx_abort  = 1'b1;
                frame_clr = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, latched control word, buffer pointer and frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ctrl_q     <= '0;
            bufp_q     <= '0;
            in_frame_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctrl_ld)       ctrl_q <= mem_rdata;
            if (bufp_ld)       bufp_q <= mem_rdata[AW-1:0];
            else if (bufp_inc) bufp_q <= bufp_q + AW'(1);
            if (frame_clr)      in_frame_q <= 1'b0;
            else if (frame_set) in_frame_q <= 1'b1;
        end
    end

    // Pending halt: armed while busy, dropped whenever the engine goes idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       halt_q <= 1'b0;
        else if (state_q != ST_IDLE && state_d == ST_IDLE) halt_q <= 1'b0;
        else if (halt && state_q != ST_IDLE)              halt_q <= 1'b1;
    end

    assign busy    = (state_q != ST_IDLE);
    assign tx_last = tx_valid && buf_end && ctrl_q[B_LAST];
    assign tx_crc  = tx_last && !ctrl_q[B_NOCRC];

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !tx_valid));
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    // R6
    wb_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata[B_USED]);
    // R4
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
    // R9
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !busy);
endmodule

// File: tb/test_tx_desc_ring_engine.sv
`timescale 1ns/1ps
module test_tx_desc_ring_engine;
    localparam int AW = 8;
    localparam logic [31:0] USED = 32'h8000_0000, LASTF = 32'h0000_8000,
                            NOCRC = 32'h0001_0000, WRAPF = 32'h4000_0000,
                            EXH = 32'h0800_0000, UNDR = 32'h1000_0000,
                            RETRY = 32'h2000_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic base_we = 1'b0, start = 1'b0, halt = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic underrun_in = 1'b0, retry_in = 1'b0;
    logic busy, mem_req, mem_we, tx_valid, tx_last, tx_crc, tx_abort;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [7:0] tx_data;

    logic [31:0] mem [0:255];
    logic tb_we = 1'b0;
    logic [7:0] tb_addr = '0;
    logic [31:0] tb_data = '0;

    logic [7:0] cap_d [0:255];
    logic cap_l [0:255];
    logic cap_c [0:255];
    int n_cap = 0, n_abort = 0, n_req = 0;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    tx_desc_ring_engine #(.AW(AW)) i_tx_desc_ring_engine (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .start(start), .halt(halt), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .underrun_in(underrun_in), .retry_in(retry_in),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_crc(tx_crc), .tx_abort(tx_abort)
    );

    // Memory model: bench loads when idle, engine accesses otherwise.
    always @(posedge clk) begin
        if (tb_we) mem[tb_addr] <= tb_data;
        else if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    // Stream monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                cap_d[n_cap[7:0]] <= tx_data;
                cap_l[n_cap[7:0]] <= tx_last;
                cap_c[n_cap[7:0]] <= tx_crc;
                n_cap <= n_cap + 1;
            end
            if (tx_abort) n_abort <= n_abort + 1;
            if (mem_req)  n_req <= n_req + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic fill_buf(input logic [7:0] w, input int nw, input logic [7:0] seed);
        for (int i = 0; i < nw; i++)
            poke(w + 8'(i), {seed + 8'(4*i+3), seed + 8'(4*i+2), seed + 8'(4*i+1), seed + 8'(4*i)} ^ 32'h5A3C_9617);
    endtask

    task automatic set_base(input logic [AW-1:0] b);
        @(negedge clk); base_we = 1'b1; base_wdata = b;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        chk(req, "engine returned idle", 32'(busy), 32'd0);
    endtask

    // Compare len captured bytes from position pos with buffer words at w.
    task automatic exp_bytes(input string req, input int pos, input logic [7:0] w, input int len);
        int bad = 0;
        logic [7:0] e;
        for (int i = 0; i < len; i++) begin
            e = mem[w + 8'(i/4)][8*(i%4) +: 8];
            if (cap_d[8'(pos+i)] !== e) bad++;
        end
        chk(req, "byte content and order", 32'(bad), 32'd0);
    endtask

    task automatic exp_flags(input string req, input int pos, input int len,
                             input logic last_at_end, input logic crc);
        int nl = 0;
        for (int i = 0; i < len; i++) if (cap_l[8'(pos+i)]) nl++;
        chk(req, "tx_last count", 32'(nl), last_at_end ? 32'd1 : 32'd0);
        if (last_at_end) begin
            chk(req, "tx_last on final byte", 32'(cap_l[8'(pos+len-1)]), 32'd1);
            chk(req, "tx_crc on final byte", 32'(cap_c[8'(pos+len-1)]), 32'(crc));
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        chk("R1", "busy after reset", 32'(busy), 32'd0);
        chk("R1", "tx_valid after reset", 32'(tx_valid), 32'd0);
        chk("R1", "mem_req after reset", 32'(mem_req), 32'd0);
    endtask

    // R2 R3 R4 R5 R6 R8: one single-buffer frame, then a used entry.
    task automatic t_single();
        int mark, rq;
        fill_buf(8'd100, 2, 8'h10);
        poke(8'd16, 32'd100); poke(8'd17, LASTF | 32'd6);
        poke(8'd19, USED | 32'd9);
        set_base(8'd16);
        mark = n_cap;
        pulse_start();
        chk("R2", "busy one cycle after start", 32'(busy), 32'd1);
        wait_idle("R2");
        chk("R3", "byte count", 32'(n_cap - mark), 32'd6);
        exp_bytes("R3", mark, 8'd100, 6);
        exp_flags("R4", mark, 6, 1'b1, 1'b1);
        chk("R5", "crc appended when bit16 clear", 32'(cap_c[8'(mark+5)]), 32'd1);
        chk("R6", "descriptor 0 written back", mem[17], USED | LASTF | 32'd6);
        chk("R8", "used descriptor untouched", mem[19], USED | 32'd9);
        rq = n_req;
        repeat (20) @(negedge clk);
        chk("R8", "no memory polling while idle", 32'(n_req - rq), 32'd0);
    endtask

    // R11 R4 R5 R6: new base, two-buffer frame without CRC, status pins set.
    task automatic t_multi();
        int mark;
        fill_buf(8'd120, 2, 8'h40);
        fill_buf(8'd130, 1, 8'h70);
        poke(8'd40, 32'd120); poke(8'd41, 32'd5);
        poke(8'd42, 32'd130); poke(8'd43, LASTF | NOCRC | 32'd3);
        poke(8'd45, USED);
        set_base(8'd40);
        underrun_in = 1'b1; retry_in = 1'b1;
        mark = n_cap;
        pulse_start();
        wait_idle("R11");
        underrun_in = 1'b0; retry_in = 1'b0;
        chk("R11", "fetch began at entry 0 of new base", 32'(n_cap - mark), 32'd8);
        exp_bytes("R4", mark, 8'd120, 5);
        exp_bytes("R4", mark + 5, 8'd130, 3);
        exp_flags("R5", mark, 8, 1'b1, 1'b0);
        chk("R6", "middle buffer has no status", mem[41], USED | 32'd5);
        chk("R6", "final buffer status bits", mem[43], USED | UNDR | RETRY | LASTF | NOCRC | 32'd3);
    endtask

    // R7: wrap flag returns to the ring base.
    task automatic t_wrap();
        int mark;
        fill_buf(8'd140, 1, 8'h90);
        fill_buf(8'd150, 1, 8'hA0);
        fill_buf(8'd160, 1, 8'hB0);
        poke(8'd60, 32'd140); poke(8'd61, LASTF | 32'd2);
        poke(8'd62, 32'd150); poke(8'd63, WRAPF | LASTF | 32'd3);
        set_base(8'd60);
        mark = n_cap;
        pulse_start();
        wait_idle("R7");
        chk("R7", "two frames then stop at used entry 0", 32'(n_cap - mark), 32'd5);
        chk("R7", "wrap bit kept in write-back", mem[63], USED | WRAPF | LASTF | 32'd3);
        poke(8'd60, 32'd160); poke(8'd61, LASTF | 32'd4);
        mark = n_cap;
        pulse_start();
        wait_idle("R7");
        chk("R7", "resumed at base entry", 32'(n_cap - mark), 32'd4);
        exp_bytes("R7", mark, 8'd160, 4);
    endtask

    // R9: ring runs dry inside a frame.
    task automatic t_exhaust();
        int mark, ab;
        fill_buf(8'd170, 1, 8'hC0);
        poke(8'd80, 32'd170); poke(8'd81, 32'd3);
        poke(8'd83, USED | 32'd7);
        set_base(8'd80);
        mark = n_cap; ab = n_abort;
        pulse_start();
        wait_idle("R9");
        chk("R9", "bytes before exhaustion", 32'(n_cap - mark), 32'd3);
        exp_flags("R9", mark, 3, 1'b0, 1'b0);
        chk("R9", "abort pulses", 32'(n_abort - ab), 32'd1);
        chk("R9", "exhausted flag written", mem[83], USED | EXH | 32'd7);
        chk("R9", "first buffer consumed", mem[81], USED | 32'd3);
    endtask

    // R10: halt mid-frame finishes the frame, then resumes on start.
    task automatic t_halt();
        int mark;
        fill_buf(8'd180, 2, 8'hD0);
        fill_buf(8'd190, 1, 8'hE0);
        poke(8'd90, 32'd180); poke(8'd91, LASTF | 32'd8);
        poke(8'd92, 32'd190); poke(8'd93, LASTF | 32'd4);
        poke(8'd95, USED);
        set_base(8'd90);
        mark = n_cap;
        pulse_start();
        repeat (3) @(negedge clk);
        halt = 1'b1; @(negedge clk); halt = 1'b0;
        wait_idle("R10");
        chk("R10", "only current frame sent", 32'(n_cap - mark), 32'd8);
        chk("R10", "next descriptor not consumed", mem[93], LASTF | 32'd4);
        mark = n_cap;
        pulse_start();
        wait_idle("R10");
        chk("R10", "resumed frame length", 32'(n_cap - mark), 32'd4);
        exp_bytes("R10", mark, 8'd190, 4);
    endtask

    // R8: used entry at frame start, exact busy timing, no write.
    task automatic t_idle_used();
        poke(8'd0, 32'd200); poke(8'd1, USED | LASTF | 32'd2);
        set_base(8'd0);
        pulse_start();
        chk("R8", "busy after start", 32'(busy), 32'd1);
        @(negedge clk);
        chk("R8", "busy during control read", 32'(busy), 32'd1);
        @(negedge clk);
        chk("R8", "busy low third cycle", 32'(busy), 32'd0);
        chk("R8", "used entry not rewritten", mem[1], USED | LASTF | 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_wrap();
        t_exhaust();
        t_halt();
        t_idle_used();
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule